// File: doc/BRIEF.md
# Integer and Branch Execute Unit

This block carries out the integer arithmetic and branch decisions of a small 32-bit processor. Each cycle it receives an 8-bit opcode, the current value of the destination register, two source register values, a 16-bit immediate and a 4-bit immediate. It produces a 32-bit result with a write enable, a branch-taken flag with an absolute 16-bit target, and a flag for opcodes it does not recognise.

Besides the usual minimum, add and add-immediate, the unit has some less common operations. One accumulates a shifted source into the destination. One subtracts the register from the immediate. One is a right shift that rounds up whenever any one bit is shifted out. A load-upper adds an offset to the source and then keeps the destination's low half. The datapath is combinational. With the `OUT_REG` parameter set (the default), every output is held in a register for one clock, and a synchronous reset clears that register.

Top module: `int_exec_unit`

## Requirements
- R1: Opcode 0x30 writes the smaller of `src_a` and `src_b`, compared as unsigned numbers.
- R2: Opcode 0x31 writes `src_a + src_b`. Opcode 0x32 writes `src_a` plus the zero-extended `imm16`. Both wrap modulo 2^32.
- R3: Opcode 0x33 writes `dst_in + (src_a << imm16)` modulo 2^32. When `imm16` is 32 or more, the shifted part is 0 and the result equals `dst_in`.
- R4: Opcode 0x34 writes the zero-extended `imm16` minus `src_a`, modulo 2^32.
- R5: Opcode 0x35 writes `src_a >> imm16` and adds 1 when any bit shifted out is 1. When `imm16` is 0, the result is `src_a`. When `imm16` is 32 or more, the result is 1 if `src_a` is nonzero and 0 otherwise.
- R6: Opcode 0x37 writes a value whose upper 16 bits are the low 16 bits of `src_a + imm16` and whose lower 16 bits are `dst_in[15:0]`.
- R7: Opcode 0x20 takes the branch when `src_a` equals the zero-extended `imm4`.
- R8: Opcode 0x21 takes the branch when `src_a > src_b`, compared as unsigned numbers.
- R9: Any other opcode sets `illegal` to 1 and drives `wr_en`, `br_taken` and `result` to 0.
- R10: Opcodes 0x30 to 0x35 and 0x37 set `wr_en` to 1 and `br_taken` to 0. The two branch opcodes set `wr_en` to 0 and `result` to 0. `br_target` equals `imm16` when `br_taken` is 1 and is 0 otherwise. `illegal` is 0 for every listed opcode.
- R11: With `OUT_REG`=1, outputs reflect the inputs present at the previous rising clock edge. A cycle with `rst` high clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opcode | input | 8 | Operation select |
| dst_in | input | 32 | Current value of the destination register |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| imm16 | input | 16 | Wide immediate: operand, shift amount or branch target |
| imm4 | input | 4 | Narrow immediate used by the compare-equal branch |
| result | output | 32 | Value to write to the destination register |
| wr_en | output | 1 | Destination write enable |
| br_taken | output | 1 | Branch taken |
| br_target | output | 16 | Absolute branch target |
| illegal | output | 1 | Opcode not recognised |

## Verification
On every cycle, the assertions check these properties: an illegal opcode stays silent; a taken branch never writes and always carries the immediate as its target; the minimum never exceeds either source; load-upper keeps the low half; and the ceiling shift differs from a plain shift by 0 or 1 only. Only the bench's scenarios can show the exact arithmetic at the edges. That includes unsigned ordering with the top bit set, wrap-around on add and reverse subtract, and saturation of shift amounts of 32 and above. It also includes zero-extension of the narrow immediate, the one-cycle output latency, and reset clearing the outputs.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int NIMM_W = 4;
    localparam int SH_W   = $clog2(XLEN);
    localparam int HALF   = XLEN / 2;

    typedef enum logic [7:0] {
        OPC_BRANCH_EQI = 8'h20,
        OPC_BRANCH_GT  = 8'h21,
        OPC_MINU       = 8'h30,
        OPC_ADD        = 8'h31,
        OPC_ADD_IMM    = 8'h32,
        OPC_SHIFT_ACC  = 8'h33,
        OPC_REV_SUB    = 8'h34,
        OPC_CEIL_SHR   = 8'h35,
        OPC_UPPER_OFS  = 8'h37
    } opc_e;

    typedef enum logic [2:0] {
        FN_NONE,
        FN_MINU,
        FN_ADD,
        FN_ADD_IMM,
        FN_SHIFT_ACC,
        FN_REV_SUB,
        FN_CEIL_SHR,
        FN_UPPER_OFS
    } arith_fn_e;

    typedef enum logic [1:0] {
        BR_NONE,
        BR_EQ_IMM,
        BR_GT_U
    } branch_fn_e;

    typedef struct packed {
        arith_fn_e  fn;
        branch_fn_e br;
        logic       writes;
        logic       bad;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0]  result;
        logic             wr_en;
        logic             br_taken;
        logic [IMM_W-1:0] target;
        logic             illegal;
    } exec_out_t;

    function automatic logic amount_saturates(input logic [IMM_W-1:0] amt);
        return amt >= IMM_W'(XLEN);
    endfunction

    function automatic logic [XLEN-1:0] shl_sat(input logic [XLEN-1:0] v,
                                                input logic [IMM_W-1:0] amt);
        logic [XLEN-1:0] r;
        if (amount_saturates(amt)) r = '0;
        else                       r = v << amt[SH_W-1:0];
        return r;
    endfunction

    function automatic logic [XLEN-1:0] shr_ceil(input logic [XLEN-1:0] v,
                                                 input logic [IMM_W-1:0] amt);
        logic [XLEN-1:0] r;
        logic [XLEN-1:0] lost_mask;
        logic            lost;
        if (amount_saturates(amt)) begin
            r = {{(XLEN-1){1'b0}}, |v};
        end else begin
            lost_mask = ~({XLEN{1'b1}} << amt[SH_W-1:0]);
            lost      = |(v & lost_mask);
            r         = (v >> amt[SH_W-1:0]) + {{(XLEN-1){1'b0}}, lost};
        end
        return r;
    endfunction

endpackage

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [7:0] opcode,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '{fn: FN_NONE, br: BR_NONE, writes: 1'b0, bad: 1'b0};
        case (opcode)
            OPC_MINU:       begin ctrl.fn = FN_MINU;      ctrl.writes = 1'b1; end
            OPC_ADD:        begin ctrl.fn = FN_ADD;       ctrl.writes = 1'b1; end
            OPC_ADD_IMM:    begin ctrl.fn = FN_ADD_IMM;   ctrl.writes = 1'b1; end
            OPC_SHIFT_ACC:  begin ctrl.fn = FN_SHIFT_ACC; ctrl.writes = 1'b1; end
            OPC_REV_SUB:    begin ctrl.fn = FN_REV_SUB;   ctrl.writes = 1'b1; end
            OPC_CEIL_SHR:   begin ctrl.fn = FN_CEIL_SHR;  ctrl.writes = 1'b1; end
            OPC_UPPER_OFS:  begin ctrl.fn = FN_UPPER_OFS; ctrl.writes = 1'b1; end
            OPC_BRANCH_EQI: ctrl.br = BR_EQ_IMM;
            OPC_BRANCH_GT:  ctrl.br = BR_GT_U;
            default:        ctrl.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/int_exec_arith.sv
module int_exec_arith
    import int_exec_pkg::*;
(
    input  arith_fn_e        fn,
    input  logic [XLEN-1:0]  dst_in,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm16,
    output logic [XLEN-1:0]  value
);
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] upper_sum;

    assign imm_ext   = {{(XLEN-IMM_W){1'b0}}, imm16};
    assign upper_sum = src_a + imm_ext;

    always_comb begin
        case (fn)
            FN_MINU:      value = (src_a < src_b) ? src_a : src_b;
            FN_ADD:       value = src_a + src_b;
            FN_ADD_IMM:   value = src_a + imm_ext;
            FN_SHIFT_ACC: value = dst_in + shl_sat(src_a, imm16);
            FN_REV_SUB:   value = imm_ext - src_a;
            FN_CEIL_SHR:  value = shr_ceil(src_a, imm16);
            FN_UPPER_OFS: value = {upper_sum[HALF-1:0], dst_in[HALF-1:0]};
            default:      value = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_branch.sv
module int_exec_branch
    import int_exec_pkg::*;
(
    input  branch_fn_e        br,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [NIMM_W-1:0] imm4,
    input  logic [IMM_W-1:0]  imm16,
    output logic              taken,
    output logic [IMM_W-1:0]  target
);
    logic [XLEN-1:0] small_ext;
    assign small_ext = {{(XLEN-NIMM_W){1'b0}}, imm4};

    always_comb begin
        case (br)
            BR_EQ_IMM: taken = (src_a == small_ext);
            BR_GT_U:   taken = (src_a > src_b);
            default:   taken = 1'b0;
        endcase
        target = taken ? imm16 : '0;
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import int_exec_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  opcode,
    input  logic [31:0] dst_in,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [15:0] imm16,
    input  logic [3:0]  imm4,
    output logic [31:0] result,
    output logic        wr_en,
    output logic        br_taken,
    output logic [15:0] br_target,
    output logic        illegal
);
    ctrl_t           ctrl;
    logic [XLEN-1:0] arith_val;
    logic            br_hit;
    logic [IMM_W-1:0] br_dest;
    exec_out_t       nxt;
    exec_out_t       cur;

    int_exec_decode u_dec (.opcode(opcode), .ctrl(ctrl));

    int_exec_arith u_arith (
        .fn(ctrl.fn), .dst_in(dst_in), .src_a(src_a), .src_b(src_b),
        .imm16(imm16), .value(arith_val)
    );

    int_exec_branch u_br (
        .br(ctrl.br), .src_a(src_a), .src_b(src_b), .imm4(imm4),
        .imm16(imm16), .taken(br_hit), .target(br_dest)
    );

    always_comb begin
        nxt.result   = ctrl.writes ? arith_val : '0;
        nxt.wr_en    = ctrl.writes;
        nxt.br_taken = br_hit;
        nxt.target   = br_dest;
        nxt.illegal  = ctrl.bad;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) cur <= '0;
                else     cur <= nxt;
            end
        end else begin : g_comb
            assign cur = nxt;
        end
    endgenerate

    assign result    = cur.result;
    assign wr_en     = cur.wr_en;
    assign br_taken  = cur.br_taken;
    assign br_target = cur.target;
    assign illegal   = cur.illegal;

    // R1: minimum never exceeds either operand
    a_r1_min_bound: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_MINU) |-> (arith_val <= src_a && arith_val <= src_b));

    // R5: ceiling shift is the plain shift or one above it
    a_r5_ceil_step: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_CEIL_SHR && imm16 < 16'd32) |->
        (arith_val - (src_a >> imm16[SH_W-1:0]) <= 32'd1));

    // R6: load-upper keeps the low half of the destination
    a_r6_low_kept: assert property (@(posedge clk) disable iff (rst)
        (opcode == OPC_UPPER_OFS) |-> (arith_val[HALF-1:0] == dst_in[HALF-1:0]));

    // R9: an unknown opcode neither writes nor branches
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!wr_en && !br_taken && result == '0));

    // R10: a taken branch never writes and carries the immediate
    a_r10_branch_no_write: assert property (@(posedge clk) disable iff (rst)
        br_hit |-> (!ctrl.writes && br_dest == imm16));

    // R10: write enable and branch are never raised together at the outputs
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && br_taken));
endmodule

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  opcode;
    logic [31:0] dst_in, src_a, src_b;
    logic [15:0] imm16;
    logic [3:0]  imm4;
    logic [31:0] result;
    logic        wr_en, br_taken, illegal;
    logic [15:0] br_target;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst(rst), .opcode(opcode), .dst_in(dst_in), .src_a(src_a),
        .src_b(src_b), .imm16(imm16), .imm4(imm4), .result(result),
        .wr_en(wr_en), .br_taken(br_taken), .br_target(br_target),
        .illegal(illegal)
    );

    // behavioural reference model
    logic [31:0] e_res;
    logic        e_wr, e_br, e_ill;
    logic [15:0] e_tgt;

    task automatic model(input logic [7:0] op, input logic [31:0] d,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] i16, input logic [3:0] i4);
        longint unsigned acc;
        int unsigned amt;
        e_res = 0; e_wr = 0; e_br = 0; e_ill = 0; e_tgt = 0;
        amt = i16;
        case (op)
            8'h30: begin e_wr = 1; e_res = (a < b) ? a : b; end
            8'h31: begin e_wr = 1; acc = longint'(a) + longint'(b); e_res = acc[31:0]; end
            8'h32: begin e_wr = 1; acc = longint'(a) + longint'(i16); e_res = acc[31:0]; end
            8'h33: begin
                e_wr = 1;
                if (amt >= 32) e_res = d;
                else begin acc = (longint'(a) << amt); e_res = d + acc[31:0]; end
            end
            8'h34: begin e_wr = 1; e_res = 32'(i16) - a; end
            8'h35: begin
                e_wr = 1;
                if (amt >= 32) e_res = (a != 0) ? 32'd1 : 32'd0;
                else begin
                    e_res = a / (32'd1 << amt);
                    if (a % (32'd1 << amt) != 0) e_res = e_res + 1;
                end
            end
            8'h37: begin
                e_wr = 1;
                acc = longint'(a) + longint'(i16);
                e_res = {acc[15:0], d[15:0]};
            end
            8'h20: e_br = (a == 32'(i4));
            8'h21: e_br = (a > b);
            default: e_ill = 1;
        endcase
        if (e_br) e_tgt = i16;
    endtask

    task automatic compare(input string req);
        checks++;
        if (result !== e_res || wr_en !== e_wr || br_taken !== e_br ||
            br_target !== e_tgt || illegal !== e_ill) begin
            errors++;
            $display("FAIL %s: got res=%h we=%b br=%b tgt=%h ill=%b exp res=%h we=%b br=%b tgt=%h ill=%b",
                     req, result, wr_en, br_taken, br_target, illegal,
                     e_res, e_wr, e_br, e_tgt, e_ill);
        end
    endtask

    task automatic run(input string req, input logic [7:0] op,
                       input logic [31:0] d, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i16,
                       input logic [3:0] i4);
        opcode = op; dst_in = d; src_a = a; src_b = b; imm16 = i16; imm4 = i4;
        model(op, d, a, b, i16, i4);
        @(posedge clk);
        #2;
        compare(req);
    endtask

    initial begin
        rst = 1; opcode = 8'h31; dst_in = 0; src_a = 32'h5; src_b = 32'h7;
        imm16 = 16'h1234; imm4 = 0;
        @(posedge clk); #2;
        // R11: reset clears outputs
        e_res = 0; e_wr = 0; e_br = 0; e_tgt = 0; e_ill = 0;
        compare("R11 reset");
        rst = 0;

        run("R1 min", 8'h30, 0, 32'h10, 32'h20, 0, 0);
        run("R1 min unsigned top bit", 8'h30, 0, 32'h8000_0000, 32'h1, 0, 0);
        run("R1 min equal", 8'h30, 0, 32'h42, 32'h42, 0, 0);
        run("R2 add wrap", 8'h31, 0, 32'hFFFF_FFFF, 32'h2, 0, 0);
        run("R2 addi zero-ext", 8'h32, 0, 32'h100, 0, 16'hFFFF, 0);
        run("R3 shift acc", 8'h33, 32'h1000, 32'h3, 0, 16'd4, 0);
        run("R3 shift acc 31", 8'h33, 32'h1, 32'h3, 0, 16'd31, 0);
        run("R3 shift acc saturate", 8'h33, 32'hABCD, 32'hFFFF, 0, 16'd40, 0);
        run("R4 reverse sub", 8'h34, 0, 32'h10, 0, 16'h100, 0);
        run("R4 reverse sub wrap", 8'h34, 0, 32'h200, 0, 16'h1, 0);
        run("R5 ceil exact", 8'h35, 0, 32'h40, 0, 16'd4, 0);
        run("R5 ceil round up", 8'h35, 0, 32'h41, 0, 16'd4, 0);
        run("R5 ceil zero amount", 8'h35, 0, 32'hDEAD_BEEF, 0, 16'd0, 0);
        run("R5 ceil amount 32", 8'h35, 0, 32'h1, 0, 16'd32, 0);
        run("R5 ceil amount 32 zero", 8'h35, 0, 32'h0, 0, 16'd32, 0);
        run("R5 ceil top", 8'h35, 0, 32'hFFFF_FFFF, 0, 16'd31, 0);
        run("R6 upper offset", 8'h37, 32'h1111_2222, 32'h0001_0005, 0, 16'h0003, 0);
        run("R6 upper wrap", 8'h37, 32'hAAAA_5555, 32'h0000_FFFF, 0, 16'h0002, 0);
        run("R7 beqi taken", 8'h20, 0, 32'hF, 0, 16'h0040, 4'hF);
        run("R7 beqi not taken", 8'h20, 0, 32'h3, 0, 16'h0040, 4'h4);
        run("R7 beqi zero-ext", 8'h20, 0, 32'h10, 0, 16'h0040, 4'h0);
        run("R8 bgt taken", 8'h21, 0, 32'h8000_0000, 32'h7FFF_FFFF, 16'hBEEF, 0);
        run("R8 bgt equal", 8'h21, 0, 32'h5, 32'h5, 16'hBEEF, 0);
        run("R8 bgt less", 8'h21, 0, 32'h4, 32'h5, 16'hBEEF, 0);
        run("R9 illegal 00", 8'h00, 32'h1, 32'h1, 32'h0, 16'h1, 4'h1);
        run("R9 illegal 36", 8'h36, 0, 32'h9, 32'h1, 16'h2, 0);
        run("R9 illegal FF", 8'hFF, 0, 32'h9, 32'h9, 16'h2, 0);
        run("R10 write after illegal", 8'h31, 0, 32'h1, 32'h2, 16'h0, 0);

        // R11: reset mid-stream blocks a legal op
        opcode = 8'h21; src_a = 32'h9; src_b = 32'h1; imm16 = 16'h77;
        rst = 1;
        @(posedge clk); #2;
        e_res = 0; e_wr = 0; e_br = 0; e_tgt = 0; e_ill = 0;
        compare("R11 reset mid-stream");
        rst = 0;
        run("R11 resume after reset", 8'h21, 0, 32'h9, 32'h1, 16'h77, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule